// File: doc/BRIEF.md
# Serial Transmitter with Sixteenth-Step Stop Length

This block turns parallel characters into an asynchronous serial stream on a single line. Each character is five to eight data bits, sent least significant bit first. A low start bit comes before the data. An optional parity bit follows the data, and a high stop period of programmable length ends the frame. Bit timing comes from an enable input that pulses sixteen times per bit time. In the one-times mode, the same input instead pulses once per bit.

The stop period is chosen by a 4-bit code in steps of one sixteenth of a bit. How the code maps to a length depends on the character length. A one-deep holding register takes the next character while the current one is shifting out, so frames can follow each other with no idle gap.

When clear-to-send gating is enabled, a character may begin only while the clear-to-send input is high. This condition is checked only at character boundaries. The request-to-send enable never stalls the transmitter, so clear-to-send gating always decides. The configuration inputs are captured when a character begins.

Top module: `uart_frac_tx`

## Requirements
- R1: After reset `txd` is 1, `busy` is 0 and `tx_ready` is 1, and the line stays high whenever no character is in progress.
- R2: A frame is a start bit at 0 lasting 16 ticks, followed by the data bits LSB first, each lasting 16 ticks. The data width is 5, 6, 7 or 8 bits for `cfg_len` codes 0, 1, 2 and 3.
- R3: With `cfg_par_en`=1, one parity bit of 16 ticks follows the data. `cfg_par_odd`=0 makes the number of ones in data plus parity even, and 1 makes it odd.
- R4: For `cfg_len` 1 to 3, the stop period at level 1 lasts 9+code ticks for `cfg_stop` 0 to 7, and 17+code ticks for `cfg_stop` 8 to 15.
- R5: For `cfg_len`=0, the stop period lasts 17+code ticks for every `cfg_stop` value.
- R6: With `cfg_one_x`=1, each start, data and parity bit lasts one tick. The stop period lasts 1 tick when `cfg_stop` bit 3 is 0 and 2 ticks when it is 1.
- R7: `tx_ready` returns to 1 while a character is still shifting. A character held in the register starts on the very tick on which the previous stop period expires.
- R8: With `cfg_cts_en`=1 and `cts`=0 at a character boundary, `txd` stays 1, `busy` stays 0 and the held character waits (`tx_ready`=0). It starts on the first tick after `cts` rises.
- R9: A fall of `cts` after a character has begun leaves that character's timing unchanged.
- R10: With `cfg_cts_en`=0, `cts` has no effect. `cfg_rts_en` never holds off a character. With both enables set, `cts` gates as in R8.
- R11: A change to any `cfg_*` input during a character does not alter that character. It applies from the next character onward.
- R12: `busy` is 1 from the tick that drives the start bit until the stop period of the last queued character expires, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | Bit-timing enable (16 per bit, or 1 per bit in one-times mode) |
| tx_data | input | DATA_W | Character to send |
| tx_valid | input | 1 | `tx_data` is offered |
| tx_ready | output | 1 | Holding register is empty |
| cfg_len | input | 2 | Data width code: 0..3 = 5..8 bits |
| cfg_par_en | input | 1 | Append a parity bit |
| cfg_par_odd | input | 1 | Parity sense: 1 odd, 0 even |
| cfg_stop | input | 4 | Stop length code |
| cfg_cts_en | input | 1 | Gate character starts with `cts` |
| cfg_rts_en | input | 1 | Request-to-send control enable (never stalls the transmitter) |
| cfg_one_x | input | 1 | One tick per bit mode |
| cts | input | 1 | Clear-to-send, active high |
| txd | output | 1 | Serial line |
| busy | output | 1 | A character is on the line |

## Verification
`txd` moves on the clock edge of a tick, and every level on the line lasts a whole number of ticks. The bench therefore samples at falling clock edges and counts how many sampled ticks each level lasts. It compares each run against a queue of expected runs. The queue is built from the requirements when each character is handed over.

Back-to-back runs are compared exactly. The high run that ends a burst merges with the idle time after it, so it is checked only as a lower bound. `busy` and `tx_ready` change one clock after a tick or an accepted handover, and they are checked several clocks later. Held-off starts are checked after a wait of dozens of ticks.

// File: rtl/uft_pkg.sv
package uft_pkg;

    localparam int unsigned TICKS_PER_BIT = 16;
    localparam int unsigned CNT_W         = 6;
    localparam int unsigned LEFT_W        = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } tx_state_e;

    typedef struct packed {
        logic [1:0] len_sel;
        logic       par_en;
        logic       par_odd;
        logic [3:0] stop_sel;
        logic       one_x;
    } tx_mode_t;

    function automatic logic [LEFT_W-1:0] data_bits(input logic [1:0] sel);
        return LEFT_W'(sel) + LEFT_W'(5);
    endfunction

    function automatic logic [CNT_W-1:0] bit_ticks(input logic one_x);
        return one_x ? CNT_W'(1) : CNT_W'(TICKS_PER_BIT);
    endfunction

endpackage

// File: rtl/uft_stop_len.sv
module uft_stop_len
    import uft_pkg::*;
(
    input  tx_mode_t             mode,
    output logic [CNT_W-1:0]     stop_ticks
);

    localparam int unsigned SHORT_BASE = TICKS_PER_BIT / 2 + 1;
    localparam int unsigned LONG_BASE  = TICKS_PER_BIT + 1;

    always_comb begin
        if (mode.one_x) begin
            stop_ticks = mode.stop_sel[3] ? CNT_W'(2) : CNT_W'(1);
        end else if (mode.len_sel == 2'd0 || mode.stop_sel[3]) begin
            stop_ticks = CNT_W'(LONG_BASE) + CNT_W'(mode.stop_sel);
        end else begin
            stop_ticks = CNT_W'(SHORT_BASE) + CNT_W'(mode.stop_sel);
        end
    end

endmodule

// File: rtl/uft_parity.sv
module uft_parity
    import uft_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic [DATA_W-1:0] data,
    input  logic [1:0]        len_sel,
    input  logic              odd,
    output logic              par
);

    always_comb begin
        par = odd;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < int'(data_bits(len_sel))) begin
                par = par ^ data[i];
            end
        end
    end

endmodule

// File: rtl/uft_hold.sv
module uft_hold #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    input  logic              take,
    output logic              hold_valid,
    output logic [DATA_W-1:0] hold_data
);

    typedef struct packed {
        logic              full;
        logic [DATA_W-1:0] data;
    } hold_t;

    hold_t q, d;

    always_comb begin
        d = q;
        if (take) begin
            d.full = 1'b0;
        end
        if (in_valid && !q.full) begin
            d.full = 1'b1;
            d.data = in_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign in_ready   = !q.full;
    assign hold_valid = q.full;
    assign hold_data  = q.data;

endmodule

// File: rtl/uft_seq.sv
module uft_seq
    import uft_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              cts,
    input  logic              cfg_cts_en,
    input  tx_mode_t          cfg,
    input  logic              hold_valid,
    input  logic [DATA_W-1:0] hold_data,
    input  logic              hold_par,
    output logic              take,
    output logic              txd,
    output logic              busy
);

    typedef struct packed {
        tx_state_e          state;
        logic [CNT_W-1:0]   cnt;
        logic [LEFT_W-1:0]  left;
        logic [DATA_W-1:0]  shreg;
        tx_mode_t           mode;
        logic               par;
        logic               txd;
    } seq_t;

    localparam seq_t SEQ_RST = '{
        state: ST_IDLE,
        cnt:   '0,
        left:  '0,
        shreg: '0,
        mode:  '0,
        par:   1'b0,
        txd:   1'b1
    };

    seq_t q, d;
    logic start_ok;
    logic launch;
    logic expire;
    logic [CNT_W-1:0] stop_ticks;

    uft_stop_len u_stop (
        .mode       (q.mode),
        .stop_ticks (stop_ticks)
    );

    always_comb begin
        d        = q;
        start_ok = hold_valid && (!cfg_cts_en || cts);
        expire   = tick && (q.state != ST_IDLE) && (q.cnt == CNT_W'(1));
        launch   = tick && start_ok &&
                   ((q.state == ST_IDLE) || (q.state == ST_STOP && q.cnt == CNT_W'(1)));

        if (tick && q.state != ST_IDLE && !expire) begin
            d.cnt = q.cnt - CNT_W'(1);
        end

        if (expire) begin
            case (q.state)
                ST_START: begin
                    d.state = ST_DATA;
                    d.cnt   = bit_ticks(q.mode.one_x);
                    d.txd   = q.shreg[0];
                    d.shreg = q.shreg >> 1;
                    d.left  = data_bits(q.mode.len_sel) - LEFT_W'(1);
                end
                ST_DATA: begin
                    if (q.left != '0) begin
                        d.cnt   = bit_ticks(q.mode.one_x);
                        d.txd   = q.shreg[0];
                        d.shreg = q.shreg >> 1;
                        d.left  = q.left - LEFT_W'(1);
                    end else if (q.mode.par_en) begin
                        d.state = ST_PAR;
                        d.cnt   = bit_ticks(q.mode.one_x);
                        d.txd   = q.par;
                    end else begin
                        d.state = ST_STOP;
                        d.cnt   = stop_ticks;
                        d.txd   = 1'b1;
                    end
                end
                ST_PAR: begin
                    d.state = ST_STOP;
                    d.cnt   = stop_ticks;
                    d.txd   = 1'b1;
                end
                ST_STOP: begin
                    d.state = ST_IDLE;
                    d.cnt   = '0;
                    d.txd   = 1'b1;
                end
                default: begin
                    d.state = ST_IDLE;
                    d.txd   = 1'b1;
                end
            endcase
        end

        if (launch) begin
            d.state = ST_START;
            d.txd   = 1'b0;
            d.cnt   = bit_ticks(cfg.one_x);
            d.mode  = cfg;
            d.shreg = hold_data;
            d.par   = hold_par;
            d.left  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= SEQ_RST;
        end else begin
            q <= d;
        end
    end

    assign take = launch;
    assign txd  = q.txd;
    assign busy = (q.state != ST_IDLE);

    // R1: no character in progress means a high line
    a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_IDLE) |-> txd);

    // R2: the start bit is driven low
    a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_START) |-> !txd);

    // R4: the stop period is driven high
    a_r4_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_STOP) |-> txd);

    // R5: five-bit characters never get a stop shorter than 17 ticks
    a_r5_len5_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_STOP && !q.mode.one_x && q.mode.len_sel == 2'd0)
            |-> (stop_ticks >= CNT_W'(17)));

    // R6: in one-times mode the start bit lasts a single tick
    a_r6_one_x_start: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_START && q.mode.one_x && tick) |=> (q.state == ST_DATA));

    // R8: a gated start only happens while clear-to-send was high
    a_r8_cts_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_START && $past(q.state) != ST_START && $past(cfg_cts_en))
            |-> $past(cts));

    // R11: the captured mode stays fixed within a character
    a_r11_mode_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state != ST_IDLE && q.state != ST_START && $past(q.state) != ST_IDLE)
            |-> $stable(q.mode));

endmodule

// File: rtl/uart_frac_tx.sv
module uart_frac_tx
    import uft_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    input  logic [1:0]        cfg_len,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic [3:0]        cfg_stop,
    input  logic              cfg_cts_en,
    input  logic              cfg_rts_en,
    input  logic              cfg_one_x,
    input  logic              cts,
    output logic              txd,
    output logic              busy
);

    tx_mode_t          cfg_word;
    logic              hold_valid;
    logic [DATA_W-1:0] hold_data;
    logic              hold_par;
    logic              take;

    assign cfg_word = '{
        len_sel:  cfg_len,
        par_en:   cfg_par_en,
        par_odd:  cfg_par_odd,
        stop_sel: cfg_stop,
        one_x:    cfg_one_x
    };

    uft_hold #(.DATA_W(DATA_W)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (tx_valid),
        .in_data    (tx_data),
        .in_ready   (tx_ready),
        .take       (take),
        .hold_valid (hold_valid),
        .hold_data  (hold_data)
    );

    uft_parity #(.DATA_W(DATA_W)) u_par (
        .data    (hold_data),
        .len_sel (cfg_len),
        .odd     (cfg_par_odd),
        .par     (hold_par)
    );

    uft_seq #(.DATA_W(DATA_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick16),
        .cts        (cts),
        .cfg_cts_en (cfg_cts_en),
        .cfg        (cfg_word),
        .hold_valid (hold_valid),
        .hold_data  (hold_data),
        .hold_par   (hold_par),
        .take       (take),
        .txd        (txd),
        .busy       (busy)
    );

    // R7: a held character is kept until the sequencer takes it
    a_r7_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_valid && !take) |=> (hold_valid && $stable(hold_data)));

    // R10: request-to-send control alone never holds off a start
    a_r10_rts_no_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rts_en && !cfg_cts_en && hold_valid && tick16 && !busy) |=> busy);

    // R12: taking a character always makes the line busy
    a_r12_busy_on_take: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> busy);

endmodule

// File: tb/tb_uart_frac_tx.sv
`timescale 1ns/1ps
module tb_uart_frac_tx;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic [7:0] tx_data = '0;
    logic       tx_valid = 1'b0;
    logic       tx_ready;
    logic [1:0] cfg_len = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic [3:0] cfg_stop = 4'd0;
    logic       cfg_cts_en = 1'b0;
    logic       cfg_rts_en = 1'b0;
    logic       cfg_one_x = 1'b0;
    logic       cts = 1'b1;
    logic       txd;
    logic       busy;

    int checks = 0;
    int failures = 0;

    typedef struct {
        logic  lvl;
        int    ticks;
        bit    exact;
        string tag;
    } run_t;

    run_t sb_q[$];

    always #4 clk = ~clk;

    uart_frac_tx dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick16      (tick16),
        .tx_data     (tx_data),
        .tx_valid    (tx_valid),
        .tx_ready    (tx_ready),
        .cfg_len     (cfg_len),
        .cfg_par_en  (cfg_par_en),
        .cfg_par_odd (cfg_par_odd),
        .cfg_stop    (cfg_stop),
        .cfg_cts_en  (cfg_cts_en),
        .cfg_rts_en  (cfg_rts_en),
        .cfg_one_x   (cfg_one_x),
        .cts         (cts),
        .txd         (txd),
        .busy        (busy)
    );

    initial begin
        forever begin
            @(posedge clk);
            #1 tick16 = ~tick16;
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int stop_expect();
        if (cfg_one_x) return cfg_stop[3] ? 2 : 1;
        if (cfg_len == 2'd0 || cfg_stop[3]) return 17 + int'(cfg_stop);
        return 9 + int'(cfg_stop);
    endfunction

    task automatic push_frame(input logic [7:0] data, input string tag, input bit exact_tail);
        int   bt;
        int   nb;
        int   acc;
        logic cur;
        logic p;
        bt  = cfg_one_x ? 1 : 16;
        nb  = int'(cfg_len) + 5;
        cur = 1'b0;
        acc = bt;
        p   = cfg_par_odd;
        for (int i = 0; i < nb; i++) begin
            p = p ^ data[i];
            if (data[i] == cur) acc += bt;
            else begin
                sb_q.push_back('{cur, acc, 1'b1, tag});
                cur = data[i];
                acc = bt;
            end
        end
        if (cfg_par_en) begin
            if (p == cur) acc += bt;
            else begin
                sb_q.push_back('{cur, acc, 1'b1, tag});
                cur = p;
                acc = bt;
            end
        end
        if (cur == 1'b1) acc += stop_expect();
        else begin
            sb_q.push_back('{cur, acc, 1'b1, tag});
            acc = stop_expect();
        end
        sb_q.push_back('{1'b1, acc, exact_tail, tag});
    endtask

    task automatic load_char(input logic [7:0] data, input string tag, input bit exact_tail);
        @(negedge clk);
        while (!tx_ready) @(negedge clk);
        tx_data  = data;
        tx_valid = 1'b1;
        push_frame(data, tag, exact_tail);
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy || !tx_ready) @(negedge clk);
    endtask

    task automatic wait_busy();
        @(negedge clk);
        while (!busy) @(negedge clk);
    endtask

    task automatic set_mode(input logic [1:0] len, input logic pen, input logic podd,
                            input logic [3:0] stop, input logic one_x);
        cfg_len     = len;
        cfg_par_en  = pen;
        cfg_par_odd = podd;
        cfg_stop    = stop;
        cfg_one_x   = one_x;
    endtask

    // monitor: measures each line level in ticks and pops the scoreboard
    initial begin
        logic  last;
        int    cnt;
        run_t  e;
        last = 1'b1;
        cnt  = 0;
        wait (rst_n);
        forever begin
            @(negedge clk);
            if (txd !== last) begin
                if (sb_q.size() == 0) begin
                    if (last == 1'b0) check(1'b0, "R2", "unexpected low run ticks", cnt, 0);
                end else begin
                    e = sb_q.pop_front();
                    check((e.lvl == last) && (e.exact ? (cnt == e.ticks) : (cnt >= e.ticks)),
                          e.tag, $sformatf("run level=%0d/exp %0d ticks", last, e.lvl),
                          cnt, e.ticks);
                end
                last = txd;
                cnt  = 0;
            end
            if (tick16) cnt++;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "R12", "watchdog expired", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        sb_q.push_back('{1'b1, 0, 1'b0, "R1"});
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(txd == 1'b1, "R1", "txd after reset", int'(txd), 1);
        check(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
        check(tx_ready == 1'b1, "R1", "tx_ready after reset", int'(tx_ready), 1);

        // stop code sweeps, 8-bit (R4) and 5-bit (R5), back-to-back pairs
        for (int code = 0; code < 16; code++) begin
            set_mode(2'd3, code[0], code[1], 4'(code), 1'b0);
            load_char(8'h5A ^ 8'(code * 7), "R4", 1'b1);
            load_char(8'h93 + 8'(code), "R4", 1'b0);
            wait_idle();
        end
        for (int code = 0; code < 16; code++) begin
            set_mode(2'd0, code[1], code[0], 4'(code), 1'b0);
            load_char(8'h16 + 8'(code * 3), "R5", 1'b1);
            load_char(8'hE9 ^ 8'(code), "R5", 1'b0);
            wait_idle();
        end

        // other widths and parity senses
        set_mode(2'd1, 1'b0, 1'b0, 4'd7, 1'b0);
        load_char(8'h2C, "R2", 1'b1);
        load_char(8'h13, "R2", 1'b0);
        wait_idle();
        set_mode(2'd2, 1'b1, 1'b0, 4'd3, 1'b0);
        load_char(8'h41, "R3", 1'b1);
        load_char(8'h07, "R3", 1'b0);
        wait_idle();
        set_mode(2'd2, 1'b1, 1'b1, 4'd12, 1'b0);
        load_char(8'h41, "R3", 1'b1);
        load_char(8'h66, "R3", 1'b0);
        wait_idle();

        // one-times mode
        set_mode(2'd3, 1'b0, 1'b0, 4'd0, 1'b1);
        load_char(8'hB2, "R6", 1'b1);
        load_char(8'h4D, "R6", 1'b0);
        wait_idle();
        set_mode(2'd1, 1'b1, 1'b1, 4'd8, 1'b1);
        load_char(8'h3A, "R6", 1'b1);
        load_char(8'h05, "R6", 1'b0);
        wait_idle();

        // holding register refills during shifting; busy tracking
        set_mode(2'd3, 1'b0, 1'b0, 4'd15, 1'b0);
        load_char(8'hC3, "R7", 1'b1);
        wait_busy();
        repeat (4) @(negedge clk);
        check(tx_ready == 1'b1, "R7", "tx_ready while shifting", int'(tx_ready), 1);
        check(busy == 1'b1, "R12", "busy mid character", int'(busy), 1);
        load_char(8'h3C, "R7", 1'b0);
        wait_idle();
        check(busy == 1'b0 && txd == 1'b1, "R12", "busy after last stop", int'(busy), 0);

        // clear-to-send low at a boundary holds the start
        cfg_cts_en = 1'b1;
        cts        = 1'b0;
        load_char(8'h99, "R8", 1'b0);
        repeat (80) @(negedge clk);
        check(txd == 1'b1, "R8", "txd while held", int'(txd), 1);
        check(busy == 1'b0, "R8", "busy while held", int'(busy), 0);
        check(tx_ready == 1'b0, "R8", "char still held", int'(tx_ready), 0);
        cts = 1'b1;
        wait_idle();

        // clear-to-send falls mid character
        load_char(8'h81, "R9", 1'b0);
        load_char(8'h7E, "R9", 1'b0);
        repeat (10) @(negedge clk);
        cts = 1'b0;
        @(negedge clk);
        while (busy) @(negedge clk);
        repeat (60) @(negedge clk);
        check(txd == 1'b1 && busy == 1'b0, "R9", "second char held after first done",
              int'(busy), 0);
        check(tx_ready == 1'b0, "R9", "second char still held", int'(tx_ready), 0);
        cts = 1'b1;
        wait_idle();

        // enable combinations
        cfg_cts_en = 1'b0;
        cts        = 1'b0;
        load_char(8'h24, "R10", 1'b0);
        repeat (4) @(negedge clk);
        check(busy == 1'b1, "R10", "cts ignored when gating off", int'(busy), 1);
        wait_idle();
        cfg_rts_en = 1'b1;
        load_char(8'h42, "R10", 1'b0);
        repeat (4) @(negedge clk);
        check(busy == 1'b1, "R10", "rts enable alone does not stall", int'(busy), 1);
        wait_idle();
        cfg_cts_en = 1'b1;
        load_char(8'h18, "R10", 1'b0);
        repeat (40) @(negedge clk);
        check(busy == 1'b0 && txd == 1'b1, "R10", "cts governs with both enables",
              int'(busy), 0);
        cts = 1'b1;
        wait_idle();
        cfg_cts_en = 1'b0;
        cfg_rts_en = 1'b0;

        // mode change during a character
        set_mode(2'd3, 1'b0, 1'b0, 4'd15, 1'b0);
        load_char(8'hF0, "R11", 1'b0);
        wait_busy();
        repeat (6) @(negedge clk);
        set_mode(2'd0, 1'b1, 1'b1, 4'd0, 1'b0);
        wait_idle();
        load_char(8'h0F, "R11", 1'b0);
        wait_idle();

        repeat (20) @(negedge clk);
        check(sb_q.size() == 1, "R2", "expected runs left over", sb_q.size(), 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule